// File: doc/BRIEF.md
# Two-Level Longest Prefix Lookup

This block maps a destination address to the outgoing port of the most specific route that covers it. Lookups run in a fixed two-stage pipeline. The first stage indexes a direct table with the upper address bits. When the entry it reads is marked as an overflow pointer, the second stage indexes a block of a second table with the remaining low address bits. A lookup therefore never takes more than two table reads. It may be issued on every cycle, and its result appears exactly two cycles later whether or not the second read was needed.

Software expands its route list into the two tables ahead of time and writes them through a single write port. Routes of up to `L1_BITS` bits go into the first table. Longer routes get a second-level block, whose entries inherit the shorter route that the first-level slot held before the block was created. Insert and delete are plain entry writes, and they may be interleaved freely with lookups. The default configuration uses a 20-bit key split 12/8 so that the arrays stay small. With `ADDR_W = 32` and `L1_BITS = 24` the block covers full IPv4 addresses.

Top module: `lpm_two_level`

## Requirements
- R1: While reset is held and on the first cycle after it, `res_valid`, `res_port` and `res_miss` are all 0.
- R2: A request with `req_valid` high at a clock edge produces exactly one result with `res_valid` high two edges later. Requests may follow one another on every cycle. No result appears without a request.
- R3: The first-level table is indexed by `req_addr[ADDR_W-1 -: L1_BITS]`. Its entry bit `ENTRY_W-1` is the pointer flag. When that flag is clear, bits `PORT_W-1:0` of the entry are the next hop.
- R4: When the pointer flag is set, entry bits `PTR_W-1:0` name a second-level block. The second-level index is `{block, req_addr[L2_BITS-1:0]}`, and the entry stored there is the next hop.
- R5: A next hop of 0 means no route. The result then has `res_miss` = 1 and `res_port` = 0. Any nonzero next hop gives `res_miss` = 0 and `res_port` equal to that hop.
- R6: Whenever `res_valid` is low, `res_port` and `res_miss` are 0.
- R7: With `wr_en` high, `wr_sel` = 0 writes `wr_data` to first-level entry `wr_addr[L1_BITS-1:0]`. `wr_sel` = 1 writes `wr_data[PORT_W-1:0]` to second-level entry `wr_addr[L2_IDX_W-1:0]`. Writing zero deletes a route.
- R8: A first-level write in the same cycle as a request, or a second-level write in the cycle after the request, is not seen by that request. Requests issued after the write see the new entry.
- R9: When overlapping routes are expanded into the tables in order of increasing length, every lookup returns the port of the longest route that covers the address, or a miss if no route covers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Destination address to look up |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | Table select: 0 first level, 1 second level |
| wr_addr | input | WADDR_W | Entry index for the write |
| wr_data | input | ENTRY_W | Entry value for the write |
| res_valid | output | 1 | Result strobe, two cycles after the request |
| res_port | output | PORT_W | Outgoing port of the longest match |
| res_miss | output | 1 | No route covers the address |

## Verification
Table updates and lookups can coincide, and they can coincide at either of the two table reads. A first-level write is placed in the very cycle a request arrives. A second-level write is placed in the cycle after a request, when that request is reading its block. In both cases the colliding request must return the old next hop, and the request that follows it must return the new one. Around these collisions, a sweep over every first-level slot and over every low-bit value of each populated block compares the results against a longest-match search over the route list.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Which table a write targets.
    typedef enum logic {
        TBL_FIRST  = 1'b0,
        TBL_SECOND = 1'b1
    } tbl_sel_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lpm_sram.sv
// Single-port-read, single-port-write synchronous array.
// A read and a write to the same entry in one cycle return the old value.
module lpm_sram #(
    parameter int DEPTH = 4096,
    parameter int WIDTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/lpm_entry_split.sv
// Splits a first-level entry into its pointer flag, block pointer and direct hop.
module lpm_entry_split #(
    parameter int PORT_W  = 6,
    parameter int PTR_W   = 4,
    parameter int ENTRY_W = 7
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic               is_ptr,
    output logic [PTR_W-1:0]   block,
    output logic [PORT_W-1:0]  hop
);

    assign is_ptr = entry[ENTRY_W-1];
    assign block  = entry[PTR_W-1:0];
    assign hop    = entry[PORT_W-1:0];

endmodule

// File: rtl/lpm_hop_select.sv
// Final stage: chooses the direct hop or the second-level hop and flags misses.
module lpm_hop_select #(
    parameter int PORT_W = 6
) (
    input  logic              s2_vld,
    input  logic              s2_ptr,
    input  logic [PORT_W-1:0] s2_hop,
    input  logic [PORT_W-1:0] l2_hop,
    output logic              res_valid,
    output logic [PORT_W-1:0] res_port,
    output logic              res_miss
);

    logic [PORT_W-1:0] chosen;

    always_comb begin
        chosen    = s2_ptr ? l2_hop : s2_hop;
        res_valid = s2_vld;
        res_port  = s2_vld ? chosen : '0;
        res_miss  = s2_vld && (chosen == '0);
    end

endmodule

// File: rtl/lpm_two_level.sv
// Two-stage longest prefix lookup over a direct first-level table and a
// block-structured second-level table.
module lpm_two_level #(
    parameter int ADDR_W    = 20,
    parameter int L1_BITS   = 12,
    parameter int L2_BLOCKS = 16,
    parameter int PORT_W    = 6,
    localparam int L2_BITS  = ADDR_W - L1_BITS,
    localparam int PTR_W    = (L2_BLOCKS > 1) ? $clog2(L2_BLOCKS) : 1,
    localparam int ENTRY_W  = lpm_pkg::max_of(PORT_W, PTR_W) + 1,
    localparam int L2_IDX_W = PTR_W + L2_BITS,
    localparam int WADDR_W  = lpm_pkg::max_of(L1_BITS, L2_IDX_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic               res_valid,
    output logic [PORT_W-1:0]  res_port,
    output logic               res_miss
);

    import lpm_pkg::*;

    localparam int L1_DEPTH = 1 << L1_BITS;
    localparam int L2_DEPTH = L2_BLOCKS << L2_BITS;

    typedef struct packed {
        logic               s1_vld;
        logic [L2_BITS-1:0] s1_low;
        logic               s2_vld;
        logic               s2_ptr;
        logic [PORT_W-1:0]  s2_hop;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    // Address split
    logic [L1_BITS-1:0] l1_idx;
    logic [L2_BITS-1:0] l2_low;
    assign l1_idx = req_addr[ADDR_W-1 -: L1_BITS];
    assign l2_low = req_addr[L2_BITS-1:0];

    // Write steering
    logic wr_l1, wr_l2;
    assign wr_l1 = wr_en && (tbl_sel_e'(wr_sel) == TBL_FIRST);
    assign wr_l2 = wr_en && (tbl_sel_e'(wr_sel) == TBL_SECOND);

    // Stage 1: first-level read
    logic [ENTRY_W-1:0] l1_entry;

    lpm_sram #(
        .DEPTH (L1_DEPTH),
        .WIDTH (ENTRY_W)
    ) u_l1_table (
        .clk     (clk),
        .rd_en   (req_valid),
        .rd_addr (l1_idx),
        .rd_data (l1_entry),
        .wr_en   (wr_l1),
        .wr_addr (wr_addr[L1_BITS-1:0]),
        .wr_data (wr_data)
    );

    logic              l1_is_ptr;
    logic [PTR_W-1:0]  l1_block;
    logic [PORT_W-1:0] l1_hop;

    lpm_entry_split #(
        .PORT_W  (PORT_W),
        .PTR_W   (PTR_W),
        .ENTRY_W (ENTRY_W)
    ) u_split (
        .entry  (l1_entry),
        .is_ptr (l1_is_ptr),
        .block  (l1_block),
        .hop    (l1_hop)
    );

    // Stage 2: conditional second-level read
    logic [PORT_W-1:0] l2_hop;
    logic              l2_rd;
    assign l2_rd = pipe_q.s1_vld && l1_is_ptr;

    lpm_sram #(
        .DEPTH (L2_DEPTH),
        .WIDTH (PORT_W)
    ) u_l2_table (
        .clk     (clk),
        .rd_en   (l2_rd),
        .rd_addr ({l1_block, pipe_q.s1_low}),
        .rd_data (l2_hop),
        .wr_en   (wr_l2),
        .wr_addr (wr_addr[L2_IDX_W-1:0]),
        .wr_data (wr_data[PORT_W-1:0])
    );

    // Pipeline next state
    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.s1_vld = req_valid;
        if (req_valid) begin
            pipe_d.s1_low = l2_low;
        end
        pipe_d.s2_vld = pipe_q.s1_vld;
        pipe_d.s2_ptr = l2_rd;
        pipe_d.s2_hop = pipe_q.s1_vld ? l1_hop : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    lpm_hop_select #(
        .PORT_W (PORT_W)
    ) u_select (
        .s2_vld    (pipe_q.s2_vld),
        .s2_ptr    (pipe_q.s2_ptr),
        .s2_hop    (pipe_q.s2_hop),
        .l2_hop    (l2_hop),
        .res_valid (res_valid),
        .res_port  (res_port),
        .res_miss  (res_miss)
    );

endmodule

// File: rtl/lpm_two_level_chk.sv
module lpm_two_level_chk #(
    parameter int PORT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              res_valid,
    input logic [PORT_W-1:0] res_port,
    input logic              res_miss
);

    // R2: every request yields a result two edges later
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 res_valid);

    // R2: no result without a request
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> ##2 !res_valid);

    // R5: a miss always reports port zero
    a_r5_miss_zero_port: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_miss) |-> (res_port == '0));

    // R6: outputs stay quiet between results
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ((res_port == '0) && !res_miss));

    // R1: the first cycle after reset carries no result
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> !res_valid);

endmodule

bind lpm_two_level lpm_two_level_chk #(
    .PORT_W (PORT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .res_valid (res_valid),
    .res_port  (res_port),
    .res_miss  (res_miss)
);

// File: tb/test_lpm_two_level.sv
`timescale 1ns/1ps
module test_lpm_two_level;

    localparam int NR = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [6:0]  wr_data = '0;
    logic        res_valid;
    logic [5:0]  res_port;
    logic        res_miss;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lpm_two_level i_lpm_two_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .res_valid (res_valid),
        .res_port  (res_port),
        .res_miss  (res_miss)
    );

    // Route list, in increasing prefix length
    int r_pfx  [NR];
    int r_len  [NR];
    int r_port [NR];

    logic [6:0] l1_sh [4096];
    logic [5:0] l2_sh [4096];
    int n_blk = 0;

    int    pend_port [2];
    string pend_tag  [2];

    task automatic add_route(input int k, input int p, input int l, input int o);
        r_pfx[k] = p; r_len[k] = l; r_port[k] = o;
    endtask

    function automatic int ref_port(input logic [19:0] a);
        int best = -1;
        int hop  = 0;
        for (int k = 0; k < NR; k++) begin
            logic [19:0] m;
            m = (r_len[k] == 0) ? 20'h0 : ~(20'hFFFFF >> r_len[k]);
            if ((((a ^ r_pfx[k][19:0]) & m) == 20'h0) && (r_len[k] > best)) begin
                best = r_len[k];
                hop  = r_port[k];
            end
        end
        return hop;
    endfunction

    // Expand the route list into first/second level images
    task automatic compile_routes();
        for (int i = 0; i < 4096; i++) begin
            l1_sh[i] = '0;
            l2_sh[i] = '0;
        end
        for (int k = 0; k < NR; k++) begin
            int idx = (r_pfx[k] >> 8) & 12'hFFF;
            if (r_len[k] <= 12) begin
                int cnt  = 1 << (12 - r_len[k]);
                int base = idx & ~(cnt - 1);
                for (int i = base; i < base + cnt; i++) begin
                    if (l1_sh[i][6]) begin
                        for (int j = 0; j < 256; j++) l2_sh[l1_sh[i][3:0] * 256 + j] = r_port[k][5:0];
                    end else begin
                        l1_sh[i] = {1'b0, r_port[k][5:0]};
                    end
                end
            end else begin
                int cnt  = 1 << (20 - r_len[k]);
                int base = (r_pfx[k] & 8'hFF) & ~(cnt - 1);
                int blk;
                if (!l1_sh[idx][6]) begin
                    for (int j = 0; j < 256; j++) l2_sh[n_blk * 256 + j] = l1_sh[idx][5:0];
                    l1_sh[idx] = {1'b1, 2'b00, n_blk[3:0]};
                    n_blk++;
                end
                blk = l1_sh[idx][3:0];
                for (int j = base; j < base + cnt; j++) l2_sh[blk * 256 + j] = r_port[k][5:0];
            end
        end
    endtask

    task automatic check_out(input int ep, input string tag);
        logic ok;
        checks++;
        if (ep < 0) ok = !res_valid && (res_port == 6'd0) && !res_miss;
        else        ok = res_valid && (res_port == ep[5:0]) && (res_miss == (ep == 0));
        if (!ok) begin
            errors++;
            $display("FAIL %s: valid=%0b port=%0d miss=%0b, expected %s port %0d",
                     tag, res_valid, res_port, res_miss, (ep < 0) ? "no result" : "result", (ep < 0) ? 0 : ep);
        end
    endtask

    // One cycle: judge the result of the request two steps back, then drive
    task automatic step(input logic rv, input logic [19:0] a, input logic we, input logic ws,
                        input logic [11:0] wa, input logic [6:0] wd, input int ep, input string tag);
        @(negedge clk);
        check_out(pend_port[1], pend_tag[1]);
        pend_port[1] = pend_port[0];
        pend_tag[1]  = pend_tag[0];
        pend_port[0] = rv ? ep : -1;
        pend_tag[0]  = rv ? tag : "R2 R6 idle";
        req_valid = rv; req_addr = a;
        wr_en = we; wr_sel = ws; wr_addr = wa; wr_data = wd;
    endtask

    task automatic lookup(input logic [19:0] a, input string tag);
        step(1'b1, a, 1'b0, 1'b0, 12'h0, 7'h0, ref_port(a), tag);
    endtask

    task automatic idle();
        step(1'b0, 20'h0, 1'b0, 1'b0, 12'h0, 7'h0, -1, "");
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung, expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] blk555;
        pend_port[0] = -1; pend_port[1] = -1;
        pend_tag[0] = "R1"; pend_tag[1] = "R1";

        add_route(0,  'h80000, 1,  13);
        add_route(1,  'h0A000, 8,  3);
        add_route(2,  'h0A400, 10, 4);
        add_route(3,  'h0AA00, 11, 9);
        add_route(4,  'h0A400, 12, 5);
        add_route(5,  'hAC100, 12, 12);
        add_route(6,  'h0A540, 14, 8);
        add_route(7,  'h0A500, 16, 6);
        add_route(8,  'hC0A80, 16, 10);
        add_route(9,  'h0A510, 20, 7);
        add_route(10, 'hC0A8F, 20, 11);
        add_route(11, 'h55566, 20, 14);
        compile_routes();

        // R1: outputs quiet under reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out(-1, "R1 in reset");
        rst_n = 1'b1;

        // R7: load both tables
        for (int i = 0; i < 4096; i++)
            step(1'b0, 20'h0, 1'b1, 1'b0, i[11:0], l1_sh[i], -1, "");
        for (int i = 0; i < n_blk * 256; i++)
            step(1'b0, 20'h0, 1'b1, 1'b1, i[11:0], {1'b0, l2_sh[i]}, -1, "");

        // R3 R5 R9: back-to-back sweep over every first-level slot
        for (int i = 0; i < 4096; i++) begin
            int lo = (i * 37) & 8'hFF;
            lookup({i[11:0], lo[7:0]}, l1_sh[i][6] ? "R4 R9 sweep" : "R3 R5 R9 sweep");
        end
        // R4 R9: every low value inside each populated block
        for (int j = 0; j < 256; j++) lookup({12'h0A5, j[7:0]}, "R4 R9 block 0A5");
        for (int j = 0; j < 256; j++) lookup({12'hC0A, j[7:0]}, "R4 R9 block C0A");
        for (int j = 0; j < 256; j++) lookup({12'h555, j[7:0]}, "R4 R5 R9 block 555");
        idle(); idle();

        // R8: first-level write in the request cycle
        step(1'b1, 20'hC0A8F, 1'b1, 1'b0, 12'hC0A, 7'd20, 11, "R8 L1 collision old");
        step(1'b1, 20'hC0A8F, 1'b0, 1'b0, 12'h0, 7'h0, 20, "R8 L1 collision new");
        step(1'b0, 20'h0, 1'b1, 1'b0, 12'hC0A, l1_sh[12'hC0A], -1, "");
        lookup(20'hC0A8F, "R8 L1 restored");

        // R8: second-level write in the cycle after the request
        blk555 = l1_sh[12'h555][3:0];
        step(1'b1, 20'h55566, 1'b0, 1'b0, 12'h0, 7'h0, 14, "R8 L2 collision old");
        step(1'b1, 20'h55566, 1'b1, 1'b1, {blk555, 8'h66}, 7'd21, 21, "R8 L2 collision new");
        idle();

        // R7 R5: deletes
        step(1'b0, 20'h0, 1'b1, 1'b0, 12'hAC1, 7'd0, -1, "");
        step(1'b1, 20'hAC155, 1'b0, 1'b0, 12'h0, 7'h0, 0, "R7 R5 L1 delete");
        step(1'b0, 20'h0, 1'b1, 1'b1, {blk555, 8'h66}, 7'd0, -1, "");
        step(1'b1, 20'h55566, 1'b0, 1'b0, 12'h0, 7'h0, 0, "R7 R5 L2 delete");
        lookup(20'h55567, "R4 R9 neighbour kept");
        idle(); idle(); idle();

        summary();
        $finish;
    end

endmodule